// File: doc/BRIEF.md
# DMA Channel Enable and Completion Control

This block governs when one DMA channel may move data and records when a programmed transfer has run to its end. Software sets a channel enable bit and loads a transfer count. A global master enable and two abort conditions, a non-maskable interrupt and an address error, also gate the channel. The block issues a one-cycle transfer strobe for each unit moved. Address generation and the data path sit outside the block and act on that strobe. Each strobe decrements the count. The completion flag is raised only when the count runs out.

In auto-request mode the channel strobes on every cycle while it is allowed to run. In external-request and peripheral-request modes it strobes only in cycles where the request input is high. A set completion flag holds the channel idle until software clears it. Clearing takes a read that returns the flag as 1, followed by a write of 0 to the flag bit. Aborts and software stops never raise the flag.

Top module: `dma_chan_ctl`

## Requirements
- R1: The asynchronous reset `rst_n` low, or the synchronous manual reset `man_rst` high for one clock, clears the enable bit, the completion flag and the count to 0. No strobe is issued in a cycle where `man_rst` is high.
- R2: In auto-request mode (`xfer_mode` = 2'b00) the channel can be permitted to run. That needs enable and master enable both 1, the completion flag 0, both abort inputs 0 and a non-zero count. While permitted, the channel strobes in every cycle, and each strobe lowers the count by one at the next edge.
- R3: In external mode (2'b01) and peripheral mode (2'b10), a permitted channel strobes only in cycles where `xfer_req` is 1. Mode 2'b11 behaves like external mode.
- R4: The completion flag (register bit 1) becomes 1 at the same edge where a strobe takes the count from 1 to 0. No further strobes follow.
- R5: While `abort_nmi` or `addr_err` is 1, no strobe is issued, the count holds and the completion flag stays 0.
- R6: Clearing the enable bit (register bit 0) or dropping `master_en` stops the strobes without setting the completion flag.
- R7: Writing 1 to the flag bit never sets or changes the flag. Writing 0 to it without a prior arming read leaves it at 1.
- R8: The flag is cleared by a write with bit 1 = 0 only when the last register access was a read that returned the flag as 1. Any other write in between cancels that arming.
- R9: While the completion flag is 1, no strobe is issued, even with the enable bit set and a non-zero count.
- R10: With the enable bit set and a count of 0, no strobe is issued and the flag stays 0.
- R11: A `cnt_load` pulse loads `cnt_wdata` into the count at the next edge. A load takes priority over a decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| man_rst | input | 1 | Synchronous manual reset, active high |
| reg_wr | input | 1 | Control register write strobe |
| reg_rd | input | 1 | Control register read strobe |
| reg_wdata | input | 2 | Write data: bit 1 flag, bit 0 enable |
| reg_rdata | output | 2 | Read data: bit 1 completion flag, bit 0 enable |
| master_en | input | 1 | Global DMA master enable |
| abort_nmi | input | 1 | NMI abort condition |
| addr_err | input | 1 | Address error abort condition |
| xfer_mode | input | 2 | 00 auto, 01 external, 10 peripheral |
| xfer_req | input | 1 | Transfer request for external/peripheral modes |
| cnt_load | input | 1 | Load the transfer count |
| cnt_wdata | input | CNT_W | Count value to load |
| xfer_count | output | CNT_W | Remaining transfer count |
| xfer_stb | output | 1 | One-cycle transfer strobe |

## Verification
The bench runs the count out in auto, external and peripheral modes. A design that raised the flag one strobe early or late, or that kept strobing after completion, would show a wrong count or a wrong strobe total. It aborts a transfer through the NMI input, the address-error input, master enable and the enable bit, where a wrong design would set the flag or let the count move. It also tries to clear the flag without an arming read, and with a write placed between the read and the clearing write. A design without proper arming would drop the flag there. It then checks that a set flag blocks restart and that an enabled zero count stays idle.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        MODE_AUTO = 2'b00,
        MODE_EXT  = 2'b01,
        MODE_PERI = 2'b10,
        MODE_RSVD = 2'b11
    } dma_mode_e;

    localparam int REG_EN_BIT   = 0;
    localparam int REG_FLAG_BIT = 1;
    localparam int REG_W        = 2;

    typedef struct packed {
        logic en;
        logic flag;
        logic armed;
    } chan_ctl_t;

endpackage

// File: rtl/dma_ctl_reg.sv
module dma_ctl_reg
    import dma_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic man_rst,
    input  logic wr,
    input  logic rd,
    input  logic wr_en_bit,
    input  logic wr_flag_bit,
    input  logic done,
    output logic en_o,
    output logic flag_o
);

    chan_ctl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.en    = wr_en_bit;
            st_d.armed = 1'b0;
            if (!wr_flag_bit && st_q.armed) begin
                st_d.flag = 1'b0;
            end
        end else if (rd && st_q.flag) begin
            st_d.armed = 1'b1;
        end
        if (done) begin
            st_d.flag = 1'b1;
        end
        if (man_rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o   = st_q.en;
    assign flag_o = st_q.flag;

endmodule

// File: rtl/dma_xfer_gate.sv
module dma_xfer_gate
    import dma_chan_pkg::*;
#(
    parameter int N_ABORT = 2
) (
    input  logic               en,
    input  logic               flag,
    input  logic               master_en,
    input  logic [N_ABORT-1:0] aborts,
    input  logic [1:0]         mode,
    input  logic               req,
    input  logic               cnt_zero,
    input  logic               man_rst,
    output logic               stb
);

    logic permit;
    logic req_ok;

    always_comb begin
        permit = en && master_en && !flag && !(|aborts) && !cnt_zero && !man_rst;
        req_ok = (dma_mode_e'(mode) == MODE_AUTO) ? 1'b1 : req;
        stb    = permit && req_ok;
    end

endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             man_rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             is_zero,
    output logic             is_last
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (man_rst) begin
            cnt_d = '0;
        end else if (load) begin
            cnt_d = load_val;
        end else if (dec) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count   = cnt_q;
    assign is_zero = (cnt_q == '0);
    assign is_last = (cnt_q == ONE);

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import dma_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             man_rst,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_wdata,
    output logic [1:0]       reg_rdata,
    input  logic             master_en,
    input  logic             abort_nmi,
    input  logic             addr_err,
    input  logic [1:0]       xfer_mode,
    input  logic             xfer_req,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] xfer_count,
    output logic             xfer_stb
);

    localparam int N_ABORT = 2;

    logic en, flag, cnt_zero, cnt_last, done;

    assign done = xfer_stb && cnt_last && !cnt_load;

    dma_ctl_reg u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .man_rst     (man_rst),
        .wr          (reg_wr),
        .rd          (reg_rd),
        .wr_en_bit   (reg_wdata[REG_EN_BIT]),
        .wr_flag_bit (reg_wdata[REG_FLAG_BIT]),
        .done        (done),
        .en_o        (en),
        .flag_o      (flag)
    );

    dma_xfer_gate #(.N_ABORT(N_ABORT)) u_gate (
        .en        (en),
        .flag      (flag),
        .master_en (master_en),
        .aborts    ({addr_err, abort_nmi}),
        .mode      (xfer_mode),
        .req       (xfer_req),
        .cnt_zero  (cnt_zero),
        .man_rst   (man_rst),
        .stb       (xfer_stb)
    );

    dma_xfer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .man_rst  (man_rst),
        .load     (cnt_load),
        .load_val (cnt_wdata),
        .dec      (xfer_stb),
        .count    (xfer_count),
        .is_zero  (cnt_zero),
        .is_last  (cnt_last)
    );

    always_comb begin
        reg_rdata = '0;
        reg_rdata[REG_FLAG_BIT] = flag;
        reg_rdata[REG_EN_BIT]   = en;
    end

endmodule

// File: rtl/dma_chan_ctl_chk.sv
module dma_chan_ctl_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             man_rst,
    input logic [1:0]       reg_rdata,
    input logic             abort_nmi,
    input logic             addr_err,
    input logic [1:0]       xfer_mode,
    input logic             xfer_req,
    input logic             cnt_load,
    input logic [CNT_W-1:0] xfer_count,
    input logic             xfer_stb
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    a_r1_manual_reset: assert property (@(posedge clk) disable iff (!rst_n)
        man_rst |=> (reg_rdata == 2'b00) && (xfer_count == '0));

    a_r2_one_per_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && !cnt_load && !man_rst) |=> (xfer_count == $past(xfer_count) - ONE));

    a_r3_request_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_mode != 2'b00 && !xfer_req) |-> !xfer_stb);

    a_r4_end_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && xfer_count == ONE && !cnt_load && !man_rst) |=> reg_rdata[1]);

    a_r5_abort_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_nmi || addr_err) |-> !xfer_stb);

    a_r7_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[1] && !(xfer_stb && xfer_count == ONE)) |=> !reg_rdata[1]);

    a_r9_flag_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[1] |-> !xfer_stb);

    a_r10_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_count == '0) |-> !xfer_stb);

endmodule

bind dma_chan_ctl dma_chan_ctl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .man_rst    (man_rst),
    .reg_rdata  (reg_rdata),
    .abort_nmi  (abort_nmi),
    .addr_err   (addr_err),
    .xfer_mode  (xfer_mode),
    .xfer_req   (xfer_req),
    .cnt_load   (cnt_load),
    .xfer_count (xfer_count),
    .xfer_stb   (xfer_stb)
);

// File: tb/dma_chan_ctl_bench.sv
module dma_chan_ctl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int WDOG_CYC   = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             man_rst = 1'b0;
    logic             reg_wr = 1'b0;
    logic             reg_rd = 1'b0;
    logic [1:0]       reg_wdata = 2'b00;
    logic [1:0]       reg_rdata;
    logic             master_en = 1'b1;
    logic             abort_nmi = 1'b0;
    logic             addr_err = 1'b0;
    logic [1:0]       xfer_mode = 2'b00;
    logic             xfer_req = 1'b0;
    logic             cnt_load = 1'b0;
    logic [CNT_W-1:0] cnt_wdata = '0;
    logic [CNT_W-1:0] xfer_count;
    logic             xfer_stb;

    typedef struct {
        string          req;
        int unsigned    cnt;
        logic [1:0]     rdata;
        int unsigned    stbs;
    } exp_item_t;

    exp_item_t sb_q[$];
    int total = 0;
    int bad = 0;
    int unsigned stb_acc = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_ctl #(.CNT_W(CNT_W)) u_dma_chan_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .man_rst    (man_rst),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .master_en  (master_en),
        .abort_nmi  (abort_nmi),
        .addr_err   (addr_err),
        .xfer_mode  (xfer_mode),
        .xfer_req   (xfer_req),
        .cnt_load   (cnt_load),
        .cnt_wdata  (cnt_wdata),
        .xfer_count (xfer_count),
        .xfer_stb   (xfer_stb)
    );

    // Monitor: compare queued expectations, then count this cycle's strobe.
    always @(negedge clk) begin
        if (!rst_n) begin
            stb_acc = 0;
        end else begin
            if (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                total++;
                if (int'(xfer_count) != it.cnt || reg_rdata !== it.rdata || stb_acc != it.stbs) begin
                    bad++;
                    $display("FAIL %s: count=%0d rdata=%b strobes=%0d expected count=%0d rdata=%b strobes=%0d",
                             it.req, xfer_count, reg_rdata, stb_acc, it.cnt, it.rdata, it.stbs);
                end
                stb_acc = 0;
            end
            if (xfer_stb === 1'b1) stb_acc++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_st(input string req, input int unsigned cnt,
                             input logic [1:0] rdata, input int unsigned stbs);
        exp_item_t it;
        it.req = req; it.cnt = cnt; it.rdata = rdata; it.stbs = stbs;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
        step(1);
    endtask

    task automatic reg_write(input logic [1:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        step(1);
        reg_wr = 1'b0; reg_wdata = 2'b00;
    endtask

    task automatic reg_read();
        reg_rd = 1'b1;
        step(1);
        reg_rd = 1'b0;
    endtask

    task automatic load_cnt(input int unsigned v);
        cnt_load = 1'b1; cnt_wdata = CNT_W'(v);
        step(1);
        cnt_load = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * WDOG_CYC);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);
        expect_st("R1 reset", 0, 2'b00, 0);

        load_cnt(5);
        expect_st("R11 load", 5, 2'b00, 0);
        reg_write(2'b01);
        step(3);
        expect_st("R2 auto strobes", 2, 2'b01, 3);
        step(1);
        expect_st("R4 end flag", 0, 2'b11, 2);
        step(3);
        expect_st("R4 stopped after end", 0, 2'b11, 0);

        reg_write(2'b11);
        expect_st("R7 write one", 0, 2'b11, 0);
        reg_write(2'b01);
        expect_st("R7 zero without read", 0, 2'b11, 0);

        load_cnt(4);
        step(2);
        expect_st("R9 flag blocks restart", 4, 2'b11, 0);

        reg_read();
        reg_write(2'b01);
        expect_st("R8 read then clear", 4, 2'b01, 0);
        step(3);
        expect_st("R4 second run ends", 0, 2'b11, 4);

        reg_read();
        reg_write(2'b11);
        reg_write(2'b01);
        expect_st("R8 disarmed by write", 0, 2'b11, 0);
        reg_read();
        reg_write(2'b00);
        expect_st("R8 clear and disable", 0, 2'b00, 0);

        reg_write(2'b01);
        step(2);
        expect_st("R10 zero count idle", 0, 2'b01, 0);

        xfer_mode = 2'b01;
        load_cnt(3);
        step(2);
        expect_st("R3 ext waits for request", 3, 2'b01, 0);
        xfer_req = 1'b1; step(1);
        xfer_req = 1'b0; step(1);
        xfer_req = 1'b1; step(1);
        xfer_req = 1'b0; step(1);
        expect_st("R3 ext request strobes", 1, 2'b01, 2);
        xfer_mode = 2'b10;
        xfer_req = 1'b1; step(1);
        xfer_req = 1'b0;
        expect_st("R4 peripheral end", 0, 2'b11, 1);
        xfer_req = 1'b1; step(2);
        xfer_req = 1'b0;
        expect_st("R9 request ignored while flag", 0, 2'b11, 0);
        reg_read();
        reg_write(2'b00);
        xfer_mode = 2'b00;
        expect_st("R8 clear again", 0, 2'b00, 0);

        abort_nmi = 1'b1;
        load_cnt(6);
        reg_write(2'b01);
        step(2);
        expect_st("R5 nmi holds", 6, 2'b01, 0);
        abort_nmi = 1'b0;
        step(2);
        addr_err = 1'b1;
        step(2);
        expect_st("R5 address error holds", 4, 2'b01, 2);
        addr_err = 1'b0;
        step(1);
        master_en = 1'b0;
        step(2);
        expect_st("R6 master disable", 3, 2'b01, 1);
        master_en = 1'b1;
        reg_write(2'b00);
        step(2);
        expect_st("R6 channel disable", 2, 2'b00, 1);

        reg_write(2'b01);
        man_rst = 1'b1;
        step(1);
        man_rst = 1'b0;
        expect_st("R1 manual reset", 0, 2'b00, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule